// File: doc/BRIEF.md
# Dual-Rate Peripheral Clock Prescaler

This block divides an oscillator clock into a machine-cycle strobe for the CPU and six separate tick strobes, one for each peripheral. Each strobe is a single-cycle pulse that fires once every 6 or once every 12 oscillator periods. All strobes come from one shared phase counter, so fast and slow strobes always stay aligned with each other.

One 8-bit control register sets the rates. Its low bit is a global double-speed enable. When that bit is clear, every strobe runs at the 12-period rate. When it is set, the CPU strobe runs at the 6-period rate, and each peripheral bit chooses between 6 periods (bit clear) and 12 periods (bit set).

The register is read and written as a whole byte at one special-function address. At reset, the global bit loads from a non-volatile configuration input. A new rate written to the register is held back until the phase counter wraps, so no strobe interval is ever cut short or stretched.

Top module: `dual_rate_prescaler`

## Requirements
- R1: During reset, register bits 7..1 clear to 0 and bit 0 takes the inverse of `nv_std_rate`. The rates in force right after reset match that register value.
- R2: A write with `sfr_wr`=1 and `sfr_addr`=0x8F stores `sfr_wdata` into the register at that clock edge. A write to any other address leaves the register unchanged.
- R3: `sfr_rdata` combinationally returns the stored register when `sfr_addr`=0x8F, and returns 0x00 for any other address.
- R4: Bit 7 always reads as 0. Writing it has no effect.
- R5: The phase counter is 0 in the first cycle after reset, counts up by one each cycle, and wraps from 11 to 0. A 12-period strobe is high only while the phase is 11.
- R6: A 6-period strobe is high only while the phase is 5 or 11.
- R7: When the active bit 0 is 0, `cpu_cyc` and all six bits of `per_tick` run at the 12-period rate, whatever bits 6..1 hold.
- R8: When the active bit 0 is 1, `cpu_cyc` runs at the 6-period rate. `per_tick[i]` is controlled by register bit i+1: 0 gives the 6-period rate and 1 gives the 12-period rate. The mapping is timer 0 = `per_tick[0]`, timer 1 = [1], timer 2 = [2], serial port = [3], counter array = [4], watchdog = [5].
- R9: A written rate becomes active only at the clock edge where the phase goes from 11 to 0. Strobes in the current 12-cycle period keep the old rates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nv_std_rate | input | 1 | Non-volatile configuration bit; its inverse loads into bit 0 at reset |
| sfr_addr | input | 8 | Special-function address |
| sfr_wr | input | 1 | Write enable |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data |
| cpu_cyc | output | 1 | CPU machine-cycle strobe |
| per_tick | output | 6 | Peripheral tick strobes |

## Verification
The assertions assume that `nv_std_rate` is steady while reset is asserted. They also assume that the address, write enable and data are stable around each rising edge.

The bench drives every input on falling edges and holds `nv_std_rate` constant through each reset. It changes register contents only through whole-byte writes. This keeps the stimulus inside the conditions the properties rely on, including writes placed partway through a 12-cycle period.

// File: rtl/pscl_pkg.sv
package pscl_pkg;
    localparam int NUM_PER = 6;
    localparam int REG_W   = 8;

    typedef struct packed {
        logic [NUM_PER-1:0] per_slow;
        logic               dbl;
    } rate_cfg_t;
endpackage

// File: rtl/pscl_ctl_reg.sv
module pscl_ctl_reg
    import pscl_pkg::*;
#(
    parameter logic [7:0] REG_ADDR = 8'h8F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nv_std_rate,
    input  logic [7:0]       addr,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output rate_cfg_t        cfg
);
    localparam int CFG_W = NUM_PER + 1;

    typedef struct packed {
        rate_cfg_t cfg;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    hit;

    always_comb begin
        hit  = (addr == REG_ADDR);
        st_d = st_q;
        if (wr && hit) begin
            st_d.cfg = rate_cfg_t'(wdata[CFG_W-1:0]);
        end
        rdata = hit ? {{(REG_W-CFG_W){1'b0}}, st_q.cfg} : '0;
        cfg   = st_q.cfg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg.per_slow <= '0;
            st_q.cfg.dbl      <= ~nv_std_rate;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: a write that hits the address lands in the register on the next edge
    p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit) |=> (st_q.cfg == rate_cfg_t'($past(wdata[CFG_W-1:0]))));
    // R2: a cycle without a hitting write leaves the register unchanged
    p_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && hit) |=> $stable(st_q.cfg));
    // R3 / R4: a miss reads zero, and bit 7 is never seen set
    p_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit |-> rdata == '0) and (rdata[REG_W-1] == 1'b0));
endmodule

// File: rtl/pscl_phase.sv
module pscl_phase
    import pscl_pkg::*;
#(
    parameter int PERIOD = 12,
    localparam int PH_W  = $clog2(PERIOD)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            nv_std_rate,
    input  rate_cfg_t       cfg_in,
    output logic [PH_W-1:0] phase,
    output rate_cfg_t       cfg_act
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);

    typedef struct packed {
        logic [PH_W-1:0] ph;
        rate_cfg_t       act;
    } ph_st_t;

    ph_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.ph == PH_LAST) begin
            st_d.ph  = '0;
            st_d.act = cfg_in;
        end else begin
            st_d.ph = st_q.ph + 1'b1;
        end
        phase   = st_q.ph;
        cfg_act = st_q.act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph           <= '0;
            st_q.act.per_slow <= '0;
            st_q.act.dbl      <= ~nv_std_rate;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: the counter wraps from the last phase to zero
    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_LAST) |=> (st_q.ph == '0));
    // R5: otherwise the counter steps up by one
    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph != PH_LAST) |=> (st_q.ph == $past(st_q.ph) + 1'b1));
    // R9: the active rates may change only on the wrap edge
    p_hold_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph != '0) |-> $stable(st_q.act));
endmodule

// File: rtl/pscl_strobes.sv
module pscl_strobes
    import pscl_pkg::*;
#(
    parameter int PERIOD = 12,
    localparam int PH_W  = $clog2(PERIOD)
) (
    input  logic [PH_W-1:0]    phase,
    input  rate_cfg_t          act,
    output logic               cpu_cyc,
    output logic [NUM_PER-1:0] per_tick
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);
    localparam logic [PH_W-1:0] PH_MID  = PH_W'(PERIOD / 2 - 1);

    logic at_mid, at_end;

    always_comb begin
        at_mid  = (phase == PH_MID);
        at_end  = (phase == PH_LAST);
        cpu_cyc = at_end | (at_mid & act.dbl);
    end

    for (genvar i = 0; i < NUM_PER; i++) begin : g_per
        always_comb begin
            per_tick[i] = at_end | (at_mid & act.dbl & ~act.per_slow[i]);
        end
    end

    // R6: a strobe only ever fires on the middle or the last phase
    always_comb begin
        p_tick_phase_r6: assert ((cpu_cyc == 1'b0 && per_tick == '0) || at_mid || at_end);
    end
endmodule

// File: rtl/dual_rate_prescaler.sv
module dual_rate_prescaler
    import pscl_pkg::*;
#(
    parameter int         PERIOD   = 12,
    parameter logic [7:0] REG_ADDR = 8'h8F
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         nv_std_rate,
    input  logic [7:0]   sfr_addr,
    input  logic         sfr_wr,
    input  logic [7:0]   sfr_wdata,
    output logic [7:0]   sfr_rdata,
    output logic         cpu_cyc,
    output logic [5:0]   per_tick
);
    localparam int PH_W = $clog2(PERIOD);

    rate_cfg_t       cfg_reg, cfg_act;
    logic [PH_W-1:0] phase;

    pscl_ctl_reg #(.REG_ADDR(REG_ADDR)) u_reg (
        .clk(clk), .rst_n(rst_n), .nv_std_rate(nv_std_rate),
        .addr(sfr_addr), .wr(sfr_wr), .wdata(sfr_wdata),
        .rdata(sfr_rdata), .cfg(cfg_reg)
    );

    pscl_phase #(.PERIOD(PERIOD)) u_phase (
        .clk(clk), .rst_n(rst_n), .nv_std_rate(nv_std_rate),
        .cfg_in(cfg_reg), .phase(phase), .cfg_act(cfg_act)
    );

    pscl_strobes #(.PERIOD(PERIOD)) u_strb (
        .phase(phase), .act(cfg_act), .cpu_cyc(cpu_cyc), .per_tick(per_tick)
    );

    // R7: with double speed inactive, strobes fire only on the last phase
    p_std_rate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_act.dbl && (cpu_cyc || per_tick != '0)) |-> (phase == PH_W'(PERIOD - 1)));
    // R8: a peripheral marked slow never fires before the CPU strobe's last phase
    p_slow_per_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((per_tick & cfg_act.per_slow) != '0) |-> (phase == PH_W'(PERIOD - 1)));
endmodule

// File: tb/test_dual_rate_prescaler.sv
module test_dual_rate_prescaler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nv_std_rate = 1'b1;
    logic [7:0] sfr_addr = 8'h00;
    logic       sfr_wr = 1'b0;
    logic [7:0] sfr_wdata = 8'h00;
    logic [7:0] sfr_rdata;
    logic       cpu_cyc;
    logic [5:0] per_tick;

    int total = 0;
    int bad = 0;
    int ph = 0;

    localparam int NVEC = 8;
    localparam logic [7:0] VEC [NVEC] = '{8'h00, 8'h7E, 8'h01, 8'h7F,
                                          8'h2B, 8'hD5, 8'h80, 8'h41};

    always #4 clk = ~clk;

    dual_rate_prescaler i_dual_rate_prescaler (
        .clk(clk), .rst_n(rst_n), .nv_std_rate(nv_std_rate),
        .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
        .sfr_rdata(sfr_rdata), .cpu_cyc(cpu_cyc), .per_tick(per_tick)
    );

    // phase model from R5
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph <= 0;
        else        ph <= (ph == 11) ? 0 : ph + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        sfr_wr = 1'b0; sfr_addr = 8'h8F;
    endtask

    task automatic do_reset(input logic nv);
        rst_n = 1'b0; nv_std_rate = nv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // wait so the phase is 0 and the last write is active (R9)
    task automatic align();
        while (ph != 11) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic measure(input logic [7:0] v);
        int c5 [7];
        int c11 [7];
        int oth [7];
        logic [6:0] fast;
        string rq;
        fast[6] = v[0];
        for (int i = 0; i < 6; i++) fast[i] = v[0] & ~v[i+1];
        rq = v[0] ? "R8" : "R7";
        for (int i = 0; i < 7; i++) begin c5[i] = 0; c11[i] = 0; oth[i] = 0; end
        for (int k = 0; k < 24; k++) begin
            logic [6:0] s;
            s = {cpu_cyc, per_tick};
            for (int i = 0; i < 7; i++) begin
                if (s[i]) begin
                    if (ph == 5) c5[i]++;
                    else if (ph == 11) c11[i]++;
                    else oth[i]++;
                end
            end
            @(negedge clk);
        end
        for (int i = 0; i < 7; i++) begin
            chk(c11[i] == 2, {rq, "/R5 ticks at phase 11"}, c11[i], 2);
            chk(c5[i] == (fast[i] ? 2 : 0), {rq, "/R6 ticks at phase 5"}, c5[i], fast[i] ? 2 : 0);
            chk(oth[i] == 0, "R6 ticks off-phase", oth[i], 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        sfr_addr = 8'h8F;
        // R1: reset with the configuration bit high gives standard rate
        do_reset(1'b1);
        #1;
        chk(sfr_rdata == 8'h00, "R1 reset value nv=1", sfr_rdata, 8'h00);
        chk(ph == 0, "R5 phase zero after reset", ph, 0);
        measure(8'h00);

        // vector table: write, read back, measure rates
        for (int n = 0; n < NVEC; n++) begin
            @(negedge clk);
            wr_reg(8'h8F, VEC[n]);
            #1;
            chk(sfr_rdata == (VEC[n] & 8'h7F), "R2/R3/R4 readback", sfr_rdata, VEC[n] & 8'h7F);
            align();
            measure(VEC[n]);
        end

        // R2: write to another address leaves the register unchanged
        wr_reg(8'h8E, 8'h55);
        #1;
        chk(sfr_rdata == 8'h41, "R2 foreign write ignored", sfr_rdata, 8'h41);
        align();
        measure(8'h41);
        // R3: other address reads zero
        sfr_addr = 8'h90; #1;
        chk(sfr_rdata == 8'h00, "R3 miss reads zero", sfr_rdata, 8'h00);
        sfr_addr = 8'h8F;

        // R9: mid-period change waits for wrap
        @(negedge clk);
        wr_reg(8'h8F, 8'h00);
        align();
        while (ph != 2) @(negedge clk);
        wr_reg(8'h8F, 8'h01);
        while (ph != 5) @(negedge clk);
        chk(cpu_cyc == 1'b0, "R9 old rate kept in period", cpu_cyc, 0);
        while (ph != 11) @(negedge clk);
        @(negedge clk);
        while (ph != 5) @(negedge clk);
        chk(cpu_cyc == 1'b1, "R9 new rate after wrap", cpu_cyc, 1);
        chk(per_tick == 6'h3F, "R9 peripherals after wrap", per_tick, 6'h3F);

        // R1: reset with the configuration bit low gives double speed
        @(negedge clk);
        do_reset(1'b0);
        #1;
        chk(sfr_rdata == 8'h01, "R1 reset value nv=0", sfr_rdata, 8'h01);
        measure(8'h01);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule